// File: doc/BRIEF.md
# Challenge-Response Integrity Monitor

This block watches a main processor from the outside. After reset it runs a startup handshake. The host presents its memory checksum, and the monitor compares it with a reference held as a parameter. The monitor then reports pass or fail on a status port. It also presents its own checksum, which the host must acknowledge as good. The monitor enables the shared output only when both halves of the handshake have succeeded.

At runtime it waits a programmable number of cycles and then raises a challenge. The challenge carries a 16-bit seed taken from a 16-entry table, and the host must strobe back the matching answer within a programmable window. A correct answer returns the monitor to its idle wait and moves it to the next table entry. A wrong answer, a late answer, an answer nobody asked for, or a failed checksum exchange moves the monitor to a sticky fault state. A 2-bit code records the cause. Only reset leaves the fault state. The downstream output enable is the AND of the monitor's own enable and an enable supplied by the host.

Top module: `cr_watchdog`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `mon_en`, `out_en`, `chal_valid` and `fault` are 0 and `csum_status` is 00 (pending).
- R2: During the handshake, a `host_csum_stb` whose `host_csum` equals `HOST_CSUM_REF` sets `csum_status` to 01 (pass). Any other value sets `csum_status` to 10 (fail) and enters the fault state with cause 00 (checksum).
- R3: `mon_en` rises only after a matching host checksum and a `host_ack_stb` with `host_ack_ok`=1 have both been seen. An acknowledge with `host_ack_ok`=0 enters the fault state with cause 00.
- R4: If the handshake is not complete within `cfg_timeout` cycles of entering it, the monitor enters the fault state with cause 10 (timeout).
- R5: `out_en` is high exactly when both `mon_en` and `host_en` are high.
- R6: After each entry to runtime idle, `chal_valid` rises after exactly `cfg_period` cycles. `cfg_period` and `cfg_timeout` must each be at least 1.
- R7: Challenge k (counting from 0 after reset) carries seed s = ((k mod 16) * 0x1F3D mod 2^16) XOR 0xA55A. The expected answer is {s[7:0], s[15:8]} XOR 0x3C96. The table index advances only on a correct answer.
- R8: A correct `rsp_data` strobed while `chal_valid` is high drops `chal_valid` on the next cycle, and no fault is raised.
- R9: A wrong `rsp_data` strobed while `chal_valid` is high enters the fault state with cause 01 (wrong answer).
- R10: A response is accepted up to the `cfg_timeout`-th cycle of `chal_valid`. If no response has arrived by the end of that cycle, the monitor enters the fault state with cause 10.
- R11: A `rsp_stb` while no challenge is outstanding and no fault is held enters the fault state with cause 11 (unexpected response).
- R12: The fault state is sticky until reset. While it is held, `mon_en` is low and no strobe changes `fault_cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_period | input | CW | Idle cycles between challenges |
| cfg_timeout | input | CW | Response and handshake window in cycles |
| host_csum_stb | input | 1 | Host checksum strobe |
| host_csum | input | 16 | Host memory checksum |
| host_ack_stb | input | 1 | Host verdict strobe on monitor checksum |
| host_ack_ok | input | 1 | Host verdict: 1 = monitor checksum good |
| mon_csum | output | 16 | Monitor's own checksum for the host |
| csum_status | output | 2 | 00 pending, 01 pass, 10 fail |
| chal_valid | output | 1 | Challenge outstanding |
| chal_seed | output | 16 | Current seed |
| rsp_stb | input | 1 | Host answer strobe |
| rsp_data | input | 16 | Host answer |
| host_en | input | 1 | Host's half of the output enable |
| mon_en | output | 1 | Monitor's half of the output enable |
| out_en | output | 1 | Combined output enable |
| fault | output | 1 | Sticky fault |
| fault_cause | output | 2 | 00 checksum, 01 wrong, 10 timeout, 11 unexpected |

## Verification
The bench places answers at every offset of the response window, including its last accepted cycle. A design with an off-by-one window would fault early there or accept a late answer. It runs more than sixteen challenges, so a table index that wraps wrongly or advances on the wrong event shows up as a bad seed. It strobes a response while idle and strobes checksum and answer inputs after a fault, so a monitor that ignored stray answers or let a fault be overwritten or cleared would report the wrong cause. The handshake is broken three ways (bad checksum, negative acknowledge, silence) to expose an enable that rises too early.

// File: rtl/cr_wdg_pkg.sv
// Shared types and seed/answer functions for the challenge-response monitor.
// Assumes a fixed 16-bit challenge data path.
package cr_wdg_pkg;
    localparam int WD_DW = 16;

    typedef enum logic [2:0] {
        ST_RESET, ST_INIT, ST_IDLE, ST_WAIT, ST_FAULT
    } wd_state_t;

    typedef enum logic [1:0] {
        CAUSE_CSUM  = 2'd0,
        CAUSE_WRONG = 2'd1,
        CAUSE_TMO   = 2'd2,
        CAUSE_UNEXP = 2'd3
    } wd_cause_t;

    localparam logic [1:0] CS_PEND = 2'd0;
    localparam logic [1:0] CS_PASS = 2'd1;
    localparam logic [1:0] CS_FAIL = 2'd2;

    // Seed for table slot k.
    function automatic logic [WD_DW-1:0] wd_seed(int unsigned k);
        logic [31:0] p;
        p = k * 32'h1F3D;
        return p[15:0] ^ 16'hA55A;
    endfunction

    // Expected answer for a given seed.
    function automatic logic [WD_DW-1:0] wd_answer(logic [WD_DW-1:0] s);
        return {s[7:0], s[15:8]} ^ 16'h3C96;
    endfunction
endpackage

// File: rtl/cr_wdg_table.sv
// Seed/answer lookup table. Entries are computed at elaboration from the
// package functions. Assumes idx is always below DEPTH.
module cr_wdg_table
    import cr_wdg_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [IW-1:0]    idx,
    output logic [WD_DW-1:0] seed,
    output logic [WD_DW-1:0] answer
);
    logic [WD_DW-1:0] seeds   [DEPTH];
    logic [WD_DW-1:0] answers [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        assign seeds[k]   = wd_seed(k);
        assign answers[k] = wd_answer(wd_seed(k));
    end

    // Select the active entry.
    assign seed   = seeds[idx];
    assign answer = answers[idx];
endmodule

// File: rtl/cr_wdg_timer.sv
// Saturating cycle counter, cleared on request. Counts from 0 in the cycle
// after a clear.
module cr_wdg_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    // Count cycles spent in the current state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      cnt <= '0;
        else if (cnt != '1)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cr_watchdog.sv
// Challenge-response integrity monitor: startup checksum handshake, periodic
// challenges, answer and deadline checks, sticky fault, and output-enable
// gating. Assumes cfg_period and cfg_timeout are at least 1 and held stable.
module cr_watchdog
    import cr_wdg_pkg::*;
#(
    parameter int              DEPTH         = 16,
    parameter int              CW            = 16,
    parameter logic [WD_DW-1:0] HOST_CSUM_REF = 16'h7E31,
    parameter logic [WD_DW-1:0] MON_CSUM      = 16'hB4C2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cfg_period,
    input  logic [CW-1:0]    cfg_timeout,
    input  logic             host_csum_stb,
    input  logic [WD_DW-1:0] host_csum,
    input  logic             host_ack_stb,
    input  logic             host_ack_ok,
    output logic [WD_DW-1:0] mon_csum,
    output logic [1:0]       csum_status,
    output logic             chal_valid,
    output logic [WD_DW-1:0] chal_seed,
    input  logic             rsp_stb,
    input  logic [WD_DW-1:0] rsp_data,
    input  logic             host_en,
    output logic             mon_en,
    output logic             out_en,
    output logic             fault,
    output logic [1:0]       fault_cause
);
    localparam int IW = $clog2(DEPTH);

    wd_state_t        st, st_nxt;
    wd_cause_t        cause_q, cause_nxt;
    logic [IW-1:0]    idx;
    logic             idx_adv;
    logic             got_csum, got_ack;
    logic [CW-1:0]    cnt;
    logic [WD_DW-1:0] exp_ans;
    logic             csum_good;
    logic             period_end, window_end;

    cr_wdg_table #(.DEPTH(DEPTH)) u_table (
        .idx    (idx),
        .seed   (chal_seed),
        .answer (exp_ans)
    );

    cr_wdg_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_nxt != st),
        .cnt   (cnt)
    );

    assign csum_good  = host_csum_stb && (host_csum == HOST_CSUM_REF);
    assign period_end = (cnt == cfg_period - 1'b1);
    assign window_end = (cnt == cfg_timeout - 1'b1);

    // Next-state and fault-cause selection, faults checked first.
    always_comb begin
        st_nxt    = st;
        cause_nxt = cause_q;
        idx_adv   = 1'b0;
        unique case (st)
            ST_RESET: begin
                if (rsp_stb) begin
                    st_nxt = ST_FAULT; cause_nxt = CAUSE_UNEXP;
                end else begin
                    st_nxt = ST_INIT;
                end
            end
            ST_INIT: begin
                if (rsp_stb) begin
                    st_nxt = ST_FAULT; cause_nxt = CAUSE_UNEXP;
                end else if (host_csum_stb && !csum_good) begin
                    st_nxt = ST_FAULT; cause_nxt = CAUSE_CSUM;
                end else if (host_ack_stb && !host_ack_ok) begin
                    st_nxt = ST_FAULT; cause_nxt = CAUSE_CSUM;
                end else if ((got_csum || csum_good) && (got_ack || host_ack_stb)) begin
                    st_nxt = ST_IDLE;
                end else if (window_end) begin
                    st_nxt = ST_FAULT; cause_nxt = CAUSE_TMO;
                end
            end
            ST_IDLE: begin
                if (rsp_stb) begin
                    st_nxt = ST_FAULT; cause_nxt = CAUSE_UNEXP;
                end else if (period_end) begin
                    st_nxt = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rsp_stb) begin
                    if (rsp_data == exp_ans) begin
                        st_nxt = ST_IDLE; idx_adv = 1'b1;
                    end else begin
                        st_nxt = ST_FAULT; cause_nxt = CAUSE_WRONG;
                    end
                end else if (window_end) begin
                    st_nxt = ST_FAULT; cause_nxt = CAUSE_TMO;
                end
            end
            default: st_nxt = ST_FAULT;
        endcase
    end

    // State, cause and table index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_RESET;
            cause_q <= CAUSE_CSUM;
            idx     <= '0;
        end else begin
            st      <= st_nxt;
            cause_q <= cause_nxt;
            if (idx_adv) idx <= (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
        end
    end

    // Handshake progress flags and checksum verdict reported to the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_csum    <= 1'b0;
            got_ack     <= 1'b0;
            csum_status <= CS_PEND;
        end else if (st == ST_INIT) begin
            if (host_csum_stb) begin
                csum_status <= csum_good ? CS_PASS : CS_FAIL;
                got_csum    <= got_csum | csum_good;
            end
            if (host_ack_stb && host_ack_ok) got_ack <= 1'b1;
        end
    end

    assign mon_csum    = MON_CSUM;
    assign chal_valid  = (st == ST_WAIT);
    assign mon_en      = (st == ST_IDLE) || (st == ST_WAIT);
    assign out_en      = mon_en & host_en;
    assign fault       = (st == ST_FAULT);
    assign fault_cause = cause_q;
endmodule

// File: rtl/cr_wdg_chk.sv
// Port-level property checker for cr_watchdog, bound to every instance.
module cr_wdg_chk
    import cr_wdg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       csum_status,
    input logic             chal_valid,
    input logic [WD_DW-1:0] chal_seed,
    input logic             rsp_stb,
    input logic [WD_DW-1:0] rsp_data,
    input logic             host_en,
    input logic             mon_en,
    input logic             out_en,
    input logic             fault,
    input logic [1:0]       fault_cause
);
    a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (mon_en && host_en));

    a_r3_enable_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_en) |-> (csum_status == CS_PASS));

    a_r8_good_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (chal_valid && rsp_stb && rsp_data == wd_answer(chal_seed))
        |=> (!fault && !chal_valid));

    a_r9_wrong_answer: assert property (@(posedge clk) disable iff (!rst_n)
        (chal_valid && rsp_stb && rsp_data != wd_answer(chal_seed))
        |=> (fault && fault_cause == CAUSE_WRONG));

    a_r11_unexpected: assert property (@(posedge clk) disable iff (!rst_n)
        (!chal_valid && !fault && rsp_stb) |=> (fault && fault_cause == CAUSE_UNEXP));

    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (fault && $stable(fault_cause) && !mon_en));
endmodule

bind cr_watchdog cr_wdg_chk u_chk (.*);

// File: tb/cr_watchdog_bench.sv
module cr_watchdog_bench;
    localparam logic [15:0] REF = 16'h7E31;

    logic        clk = 0, rst_n = 0;
    logic [15:0] cfg_period = 16'd4, cfg_timeout = 16'd6;
    logic        host_csum_stb = 0, host_ack_stb = 0, host_ack_ok = 0;
    logic [15:0] host_csum = 0;
    logic [15:0] mon_csum;
    logic [1:0]  csum_status;
    logic        chal_valid;
    logic [15:0] chal_seed;
    logic        rsp_stb = 0;
    logic [15:0] rsp_data = 0;
    logic        host_en = 0, mon_en, out_en, fault;
    logic [1:0]  fault_cause;

    int nchk = 0, nbad = 0, cycles = 0;
    bit done = 0;

    cr_watchdog u_cr_watchdog (.*);

    always #4 clk = ~clk;

    function automatic logic [15:0] b_seed(int k);
        int v;
        v = ((k % 16) * 'h1F3D) % 65536;
        return 16'(v) ^ 16'hA55A;
    endfunction
    function automatic logic [15:0] b_ans(logic [15:0] s);
        return {s[7:0], s[15:8]} ^ 16'h3C96;
    endfunction

    // Behavioural reference: phase 0 reset, 1 handshake, 2 idle, 3 wait, 4 fault.
    int m_ph = 0, m_cnt = 0, m_k = 0, m_cause = 0, m_stat = 0;
    bit m_gc = 0, m_ga = 0;
    always @(posedge clk) begin
        int np;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_k = 0; m_cause = 0; m_stat = 0; m_gc = 0; m_ga = 0;
        end else begin
            np = m_ph;
            if (m_ph == 0) begin
                if (rsp_stb) begin np = 4; m_cause = 3; end else np = 1;
            end else if (m_ph == 1) begin
                if (host_csum_stb) m_stat = (host_csum == REF) ? 1 : 2;
                if (rsp_stb) begin np = 4; m_cause = 3; end
                else if (host_csum_stb && host_csum != REF) begin np = 4; m_cause = 0; end
                else if (host_ack_stb && !host_ack_ok) begin np = 4; m_cause = 0; end
                else begin
                    if (host_csum_stb) m_gc = 1;
                    if (host_ack_stb) m_ga = 1;
                    if (m_gc && m_ga) np = 2;
                    else if (m_cnt == cfg_timeout - 1) begin np = 4; m_cause = 2; end
                end
            end else if (m_ph == 2) begin
                if (rsp_stb) begin np = 4; m_cause = 3; end
                else if (m_cnt == cfg_period - 1) np = 3;
            end else if (m_ph == 3) begin
                if (rsp_stb) begin
                    if (rsp_data == b_ans(b_seed(m_k))) begin np = 2; m_k++; end
                    else begin np = 4; m_cause = 1; end
                end else if (m_cnt == cfg_timeout - 1) begin np = 4; m_cause = 2; end
            end
            m_cnt = (np != m_ph) ? 0 : ((m_cnt < 65535) ? m_cnt + 1 : m_cnt);
            m_ph = np;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // Advance one cycle and compare every output with the reference.
    task automatic step();
        bit me;
        @(negedge clk);
        me = (m_ph == 2 || m_ph == 3);
        chk(mon_en == me, "R3 mon_en", mon_en, me);
        chk(out_en == (me && host_en), "R5 out_en", out_en, me && host_en);
        chk(chal_valid == (m_ph == 3), "R6 chal_valid", chal_valid, m_ph == 3);
        if (m_ph == 3) chk(chal_seed == b_seed(m_k), "R7 seed", chal_seed, b_seed(m_k));
        chk(fault == (m_ph == 4), "R12 fault", fault, m_ph == 4);
        if (m_ph == 4) chk(fault_cause == m_cause, "R11 cause", fault_cause, m_cause);
        chk(csum_status == m_stat, "R2 status", csum_status, m_stat);
    endtask

    task automatic do_reset();
        rst_n = 0; rsp_stb = 0; host_csum_stb = 0; host_ack_stb = 0; host_en = 1;
        repeat (3) step();
        rst_n = 1;
        step();
        chk(!mon_en && !out_en && !fault && !chal_valid && csum_status == 0,
            "R1 after reset", {mon_en, fault, chal_valid, csum_status}, 0);
    endtask

    task automatic send_csum(logic [15:0] v);
        host_csum_stb = 1; host_csum = v; step(); host_csum_stb = 0;
    endtask
    task automatic send_ack(bit ok);
        host_ack_stb = 1; host_ack_ok = ok; step(); host_ack_stb = 0;
    endtask
    task automatic pulse_rsp(logic [15:0] v);
        rsp_stb = 1; rsp_data = v; step(); rsp_stb = 0;
    endtask
    task automatic wait_chal();
        for (int i = 0; i < 200 && !chal_valid; i++) step();
    endtask

    initial begin
        do_reset();
        send_csum(REF);
        chk(csum_status == 1 && !mon_en, "R2 pass status", csum_status, 1);
        send_ack(1);
        chk(mon_en == 1, "R3 enable after handshake", mon_en, 1);
        begin
            int n = 0;
            while (!chal_valid && n < 100) begin step(); n++; end
            chk(n == cfg_period, "R6 period", n, cfg_period);
        end
        for (int k = 0; k < 18; k++) begin
            logic [15:0] s;
            host_en = (k % 3) != 0;
            wait_chal();
            s = chal_seed;
            chk(s == b_seed(k), "R7 cyclic seed", s, b_seed(k));
            repeat (k % 6) step();
            pulse_rsp(b_ans(s));
            chk(!fault && !chal_valid, "R8 accepted (R10 edge)", fault, 0);
        end
        wait_chal();
        pulse_rsp(b_ans(chal_seed) ^ 16'h0001);
        chk(fault && fault_cause == 1, "R9 wrong answer", fault_cause, 1);
        pulse_rsp(16'h1234);
        send_csum(16'h0000);
        repeat (3) step();
        chk(fault && fault_cause == 1 && !mon_en, "R12 sticky", fault_cause, 1);

        do_reset(); send_csum(REF); send_ack(1);
        wait_chal();
        repeat (cfg_timeout) step();
        chk(fault && fault_cause == 2, "R10 timeout", fault_cause, 2);

        do_reset(); send_csum(REF); send_ack(1);
        pulse_rsp(16'h0042);
        chk(fault && fault_cause == 3, "R11 unexpected", fault_cause, 3);

        do_reset();
        send_csum(REF ^ 16'h0100);
        chk(csum_status == 2 && fault && fault_cause == 0, "R2 bad checksum", csum_status, 2);

        do_reset(); send_csum(REF); send_ack(0);
        chk(fault && fault_cause == 0 && !mon_en, "R3 negative ack", fault_cause, 0);

        do_reset(); send_csum(REF);
        chk(!mon_en, "R3 no enable without ack", mon_en, 0);
        repeat (cfg_timeout) step();
        chk(fault && fault_cause == 2 && !mon_en, "R4 handshake timeout", fault_cause, 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            nbad++; nchk++;
            $display("FAIL watchdog expired act=%0d exp=0", cycles);
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end
endmodule